// File: doc/BRIEF.md
# Fault-Only-First Load Length Trimmer

This block steers a unit-stride vector load that may stop early on a fault. The load is cut into register-sized micro-operations, and the memory side reports each one in order. For each report the block works out how many elements the micro-operation holds and which element, if any, faulted. It then decides whether the fault is a real trap or whether it only shortens the vector length. It also gives a per-element write enable, so that the register file writes only active, in-range elements that come before the fault.

A load begins with a `start` pulse that carries the requested vector length and an element-width code. The block then moves through three states. IDLE waits for `start`. Taking `start` leads to RUN, or straight to REPORT when the length is zero. RUN accepts one micro-operation report per cycle in which `up_valid` is high. When the report for the final micro-operation is accepted, RUN moves to REPORT. REPORT lasts one cycle, raises `done` with the outcome, and always returns to IDLE. The outcome is either a trimmed length with a request to clear the restart index, or a trap carrying the faulting address.

Top module: `ffl_trim`

## Requirements
- R1: After reset `done`, `busy`, `up_cnt` and `elem_we` are all zero.
- R2: The element-width code `eew_sel` selects 8, 16, 32 or 64 bits for the codes 0, 1, 2 and 3. Each micro-operation holds the smaller of the remaining length and VLEN divided by the element width. `up_cnt` shows this count while a report is being accepted.
- R3: A micro-operation's fault index is (fault address minus micro base) shifted right by `eew_sel`, limited to the micro-operation's element count. Without a fault, the index equals the element count.
- R4: A fault at index 0 of the first micro-operation is a trap. At `done`, `trap_valid` is 1, `trap_addr` holds the faulting address, `new_vl` equals the requested length and `vstart_clr` is 0.
- R5: Any other fault is suppressed and trims the length. `trap_valid` stays 0 and `vstart_clr` is 1 at `done`.
- R6: `new_vl` is the sum of the fault indices in order, up to and including the first micro-operation that faulted. Without any fault it equals the requested length.
- R7: Once a micro-operation has trimmed or trapped, later faults change neither `new_vl`, the trap outputs nor `addr_err`.
- R8: `done` is a one-cycle pulse in the cycle after the last report is accepted, or in the cycle after `start` when the length is 0 (`new_vl` is then 0). Outside `done`, all result outputs are 0.
- R9: `elem_we[i]` is 1 only when a report is being accepted, element i is active (`mask_on` is 0, or `mask_bits[i]` is 1), i is below `up_cnt`, and i is below the fault index.
- R10: A fault address below the micro base raises `addr_err` at `done`. Such a fault is handled as a fault at element 0.
- R11: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (accepted only in IDLE) |
| vl_in | input | VLW | Requested vector length |
| eew_sel | input | 2 | Element width code: 0=8, 1=16, 2=32, 3=64 bits |
| up_valid | input | 1 | A micro-operation report is present |
| up_base | input | AW | Base byte address of the micro-operation |
| up_fault | input | 1 | The micro-operation faulted |
| up_fault_addr | input | AW | Faulting byte address |
| mask_on | input | 1 | Element masking is in force |
| mask_bits | input | MAXE | Per-element mask of the current micro-operation |
| elem_we | output | MAXE | Per-element destination write enable |
| up_cnt | output | CW | Element count of the current micro-operation |
| busy | output | 1 | High in RUN |
| done | output | 1 | Result pulse (REPORT) |
| new_vl | output | VLW | Resulting vector length |
| vstart_clr | output | 1 | Clear the restart index (no trap) |
| trap_valid | output | 1 | Raise the fault as a trap |
| trap_addr | output | AW | Address of the trapping fault |
| addr_err | output | 1 | Fault address was below the micro base |

## Verification
On every cycle the assertions check the following:
- `done` is a single-cycle pulse that follows the end of RUN.
- Exactly one of trap and clear-restart accompanies each result.
- The trimmed length never exceeds the requested one.
- Write enables appear only while a report is accepted, and never outnumber the micro-operation's element count.
- The latched length holds steady through RUN, even when `start` is raised in the middle of a load.

The exact trimmed sum, and the stop at the first faulting micro-operation, can only be shown by the bench's scenarios. The same holds for clamping an out-of-range index, the split between a trap and a trim, the below-base error, and the per-element enable pattern under masks.

// File: rtl/ffl_pkg.sv
package ffl_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_RUN    = 2'd1,
        S_REPORT = 2'd2
    } ffl_state_t;
endpackage

// File: rtl/ffl_fault_calc.sv
module ffl_fault_calc #(
    parameter int AW = 32,
    parameter int CW = 5
) (
    input  logic          fault,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] faddr,
    input  logic [1:0]    eew_sel,
    input  logic [CW-1:0] cnt,
    input  logic          first_micro,
    output logic [CW-1:0] fidx,
    output logic          trap_hit,
    output logic          trim_hit,
    output logic          below
);
    logic [AW-1:0] offset;
    logic [AW-1:0] idx_full;

    always_comb begin
        below    = fault && (faddr < base);
        offset   = below ? '0 : (faddr - base);
        idx_full = offset >> eew_sel;
        if (!fault)
            fidx = cnt;
        else if (idx_full >= AW'(cnt))
            fidx = cnt;
        else
            fidx = idx_full[CW-1:0];
        trap_hit = fault && first_micro && (idx_full == '0);
        trim_hit = fault && !trap_hit;
    end
endmodule

// File: rtl/ffl_elem_we.sv
module ffl_elem_we #(
    parameter int MAXE = 16,
    parameter int CW   = 5
) (
    input  logic            en,
    input  logic            mask_on,
    input  logic [MAXE-1:0] mask_bits,
    input  logic [CW-1:0]   cnt,
    input  logic [CW-1:0]   fidx,
    output logic [MAXE-1:0] we
);
    for (genvar i = 0; i < MAXE; i++) begin : g_elem
        assign we[i] = en && (!mask_on || mask_bits[i])
                       && (CW'(i) < cnt) && (CW'(i) < fidx);
    end
endmodule

// File: rtl/ffl_trim.sv
module ffl_trim
    import ffl_pkg::*;
#(
    parameter int VLEN      = 128,
    parameter int AW        = 32,
    parameter int MAX_MICRO = 8,
    localparam int MAXE     = VLEN / 8,
    localparam int CW       = $clog2(MAXE + 1),
    localparam int VLW      = $clog2(MAXE * MAX_MICRO + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [VLW-1:0]  vl_in,
    input  logic [1:0]      eew_sel,
    input  logic            up_valid,
    input  logic [AW-1:0]   up_base,
    input  logic            up_fault,
    input  logic [AW-1:0]   up_fault_addr,
    input  logic            mask_on,
    input  logic [MAXE-1:0] mask_bits,
    output logic [MAXE-1:0] elem_we,
    output logic [CW-1:0]   up_cnt,
    output logic            busy,
    output logic            done,
    output logic [VLW-1:0]  new_vl,
    output logic            vstart_clr,
    output logic            trap_valid,
    output logic [AW-1:0]   trap_addr,
    output logic            addr_err
);
    ffl_state_t state, nxt;

    logic [VLW-1:0] vl_q, rem_q, acc_q;
    logic [1:0]     eew_q;
    logic           first_q, stop_q, trap_q, err_q;
    logic [AW-1:0]  trap_addr_q;

    logic [CW-1:0]  vlmax, cnt, fidx;
    logic           last, accept;
    logic           trap_hit, trim_hit, below;

    always_comb begin
        vlmax  = CW'(MAXE >> eew_q);
        cnt    = (rem_q < VLW'(vlmax)) ? rem_q[CW-1:0] : vlmax;
        last   = (rem_q <= VLW'(vlmax));
        accept = (state == S_RUN) && up_valid;
    end

    ffl_fault_calc #(.AW(AW), .CW(CW)) u_calc (
        .fault       (up_fault),
        .base        (up_base),
        .faddr       (up_fault_addr),
        .eew_sel     (eew_q),
        .cnt         (cnt),
        .first_micro (first_q),
        .fidx        (fidx),
        .trap_hit    (trap_hit),
        .trim_hit    (trim_hit),
        .below       (below)
    );

    ffl_elem_we #(.MAXE(MAXE), .CW(CW)) u_we (
        .en        (accept),
        .mask_on   (mask_on),
        .mask_bits (mask_bits),
        .cnt       (cnt),
        .fidx      (fidx),
        .we        (elem_we)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = (vl_in == '0) ? S_REPORT : S_RUN;
            S_RUN:    if (up_valid && last) nxt = S_REPORT;
            S_REPORT: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // per-load bookkeeping of the running length and outcome
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q        <= '0;
            rem_q       <= '0;
            acc_q       <= '0;
            eew_q       <= '0;
            first_q     <= 1'b0;
            stop_q      <= 1'b0;
            trap_q      <= 1'b0;
            err_q       <= 1'b0;
            trap_addr_q <= '0;
        end else if (state == S_IDLE && start) begin
            vl_q        <= vl_in;
            rem_q       <= vl_in;
            acc_q       <= '0;
            eew_q       <= eew_sel;
            first_q     <= 1'b1;
            stop_q      <= 1'b0;
            trap_q      <= 1'b0;
            err_q       <= 1'b0;
            trap_addr_q <= '0;
        end else if (accept) begin
            rem_q   <= rem_q - VLW'(cnt);
            first_q <= 1'b0;
            if (!stop_q) begin
                acc_q <= acc_q + VLW'(fidx);
                if (trap_hit || trim_hit) stop_q <= 1'b1;
                if (trap_hit) begin
                    trap_q      <= 1'b1;
                    trap_addr_q <= up_fault_addr;
                end
                if (below) err_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy       = 1'b0;
        done       = 1'b0;
        up_cnt     = '0;
        new_vl     = '0;
        vstart_clr = 1'b0;
        trap_valid = 1'b0;
        trap_addr  = '0;
        addr_err   = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_RUN: begin
                busy   = 1'b1;
                up_cnt = up_valid ? cnt : '0;
            end
            S_REPORT: begin
                done       = 1'b1;
                new_vl     = trap_q ? vl_q : acc_q;
                vstart_clr = !trap_q;
                trap_valid = trap_q;
                trap_addr  = trap_addr_q;
                addr_err   = err_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ffl_trim_chk.sv
module ffl_trim_chk #(
    parameter int MAXE = 16,
    parameter int CW   = 5,
    parameter int VLW  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            up_valid,
    input logic [MAXE-1:0] elem_we,
    input logic [CW-1:0]   up_cnt,
    input logic            vstart_clr,
    input logic            trap_valid,
    input logic [VLW-1:0]  new_vl,
    input logic [VLW-1:0]  vl_q
);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (trap_valid ^ vstart_clr));

    p_vl_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_vl <= vl_q));

    p_we_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|elem_we) |-> (busy && up_valid));

    p_we_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && up_valid) |-> ($countones(elem_we) <= int'(up_cnt)));

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && up_valid) |-> (up_cnt != '0 && int'(up_cnt) <= MAXE));

    p_len_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(vl_q));
endmodule

bind ffl_trim ffl_trim_chk #(.MAXE(MAXE), .CW(CW), .VLW(VLW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .up_valid   (up_valid),
    .elem_we    (elem_we),
    .up_cnt     (up_cnt),
    .vstart_clr (vstart_clr),
    .trap_valid (trap_valid),
    .new_vl     (new_vl),
    .vl_q       (vl_q)
);

// File: tb/ffl_trim_test.sv
module ffl_trim_test;
    localparam int CLK_P = 10;
    localparam int VLEN  = 128;
    localparam int AW    = 32;
    localparam int MAXE  = VLEN / 8;
    localparam int CW    = $clog2(MAXE + 1);
    localparam int VLW   = $clog2(MAXE * 8 + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [VLW-1:0]  vl_in = '0;
    logic [1:0]      eew_sel = '0;
    logic            up_valid = 1'b0;
    logic [AW-1:0]   up_base = '0;
    logic            up_fault = 1'b0;
    logic [AW-1:0]   up_fault_addr = '0;
    logic            mask_on = 1'b0;
    logic [MAXE-1:0] mask_bits = '0;
    logic [MAXE-1:0] elem_we;
    logic [CW-1:0]   up_cnt;
    logic            busy, done, vstart_clr, trap_valid, addr_err;
    logic [VLW-1:0]  new_vl;
    logic [AW-1:0]   trap_addr;

    ffl_trim #(.VLEN(VLEN), .AW(AW), .MAX_MICRO(8)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
        .eew_sel(eew_sel), .up_valid(up_valid), .up_base(up_base),
        .up_fault(up_fault), .up_fault_addr(up_fault_addr),
        .mask_on(mask_on), .mask_bits(mask_bits), .elem_we(elem_we),
        .up_cnt(up_cnt), .busy(busy), .done(done), .new_vl(new_vl),
        .vstart_clr(vstart_clr), .trap_valid(trap_valid),
        .trap_addr(trap_addr), .addr_err(addr_err)
    );

    always #(CLK_P / 2) clk = ~clk;

    int errs   = 0;
    int checks = 0;
    int f_at[8];        // -1: no fault, -2: address below base, else element
    bit glitch = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_f();
        for (int k = 0; k < 8; k++) f_at[k] = -1;
    endtask

    task automatic run_op(input int vl, input int eew);
        int vlmax, esz, rem, m, acc, tad, cnt, fidx, base, faddr;
        bit stop, trap, err, flt, below, expb;
        logic [MAXE-1:0] exp_we;
        vlmax = MAXE >> eew; esz = 1 << eew; rem = vl; m = 0; acc = 0;
        tad = 0; stop = 0; trap = 0; err = 0;
        @(negedge clk);
        start = 1'b1; vl_in = VLW'(vl); eew_sel = 2'(eew);
        @(negedge clk);
        start = 1'b0;
        while (rem > 0) begin
            cnt = (rem < vlmax) ? rem : vlmax;
            base = 32'h1000 + m * (VLEN / 8);
            fidx = cnt; flt = 0; below = 0; faddr = 0;
            if (f_at[m] >= 0) begin
                flt = 1; faddr = base + f_at[m] * esz;
                fidx = (f_at[m] < cnt) ? f_at[m] : cnt;
            end else if (f_at[m] == -2) begin
                flt = 1; below = 1; faddr = base - 4; fidx = 0;
            end
            up_valid = 1'b1; up_base = AW'(base);
            up_fault = flt; up_fault_addr = AW'(faddr);
            if (glitch && m == 0) begin start = 1'b1; vl_in = VLW'(5); end
            #1;
            for (int i = 0; i < MAXE; i++) begin
                expb = (!mask_on || mask_bits[i]) && (i < cnt) && (i < fidx);
                exp_we[i] = expb;
            end
            chk("R2 up_cnt", up_cnt, cnt);
            chk("R9 elem_we", elem_we, exp_we);
            chk("R8 done low during run", done, 0);
            chk("R11 busy", busy, 1);
            if (!stop) begin
                acc += fidx;
                if (flt) begin
                    stop = 1;
                    if (m == 0 && fidx == 0) begin trap = 1; tad = faddr; end
                    if (below) err = 1;
                end
            end
            rem -= cnt; m++;
            @(negedge clk);
            start = 1'b0;
        end
        up_valid = 1'b0; up_fault = 1'b0;
        #1;
        chk("R8 done", done, 1);
        chk("R6 new_vl", new_vl, trap ? vl : acc);
        chk("R4 trap_valid", trap_valid, trap);
        chk("R5 vstart_clr", vstart_clr, !trap);
        chk("R4 trap_addr", trap_addr, trap ? tad : 0);
        chk("R10 addr_err", addr_err, err);
        @(negedge clk);
        #1;
        chk("R8 done pulse", done, 0);
        chk("R8 results idle", {trap_valid, vstart_clr, addr_err}, 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        clr_f();
        #(CLK_P * 3);
        #1;
        chk("R1 done reset", done, 0);
        chk("R1 busy reset", busy, 0);
        chk("R1 elem_we reset", elem_we, 0);
        chk("R1 up_cnt reset", up_cnt, 0);
        rst_n = 1'b1;

        // R6: no fault, three micros of 16,16,8 bytes
        clr_f(); run_op(40, 0);
        // R5/R7: trim in micro 1 at element 5, later fault ignored
        clr_f(); f_at[1] = 5; f_at[2] = 2; run_op(40, 0);
        // R3/R9: 32-bit elements, masked, trim at element 3 of micro 0
        clr_f(); mask_on = 1'b1; mask_bits = 16'hA5A5; f_at[0] = 3; run_op(20, 2);
        // R4/R7: trap at element 0 of micro 0, later fault ignored
        clr_f(); mask_on = 1'b0; f_at[0] = 0; f_at[1] = 1; run_op(10, 1);
        // R8: zero length
        clr_f(); run_op(0, 0);
        // R10/R11: below-base fault in micro 1, start raised mid-load
        clr_f(); glitch = 1; f_at[1] = -2; run_op(9, 3); glitch = 0;
        // R3 clamp: fault index beyond element count
        clr_f(); mask_on = 1'b1; mask_bits = 16'h0FF0; f_at[0] = 20; run_op(16, 0);
        // R2: longest load
        clr_f(); mask_on = 1'b0; run_op(128, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule